// File: doc/BRIEF.md
# Attribute-Gated Write Combiner

This block sits between a source of narrow writes and a 64-bit AXI4-style write channel. Every incoming request carries a byte address, lane-placed data, a byte strobe and a 4-bit cache attribute. Bit 1 of that attribute is the modifiable flag. When it is set, the target is ordinary memory. Writes that land in the same 64-bit-aligned word and carry the same attribute value are gathered into one pending beat. A strobe mask records exactly which bytes have been written.

When the modifiable flag is clear, the target is treated as a device. Each such write leaves alone, unchanged and in program order, after any merged beat that was already pending. A pending beat is released for one of four reasons:
- a write arrives that cannot join it,
- a device write arrives,
- eight cycles pass with no new write accepted,
- the flush input is asserted.

Each released beat goes out as a single-beat burst on simple AW/W/B valid-ready handshakes. When the beat's write response comes back, the block raises one completion pulse for every original write the beat carried.

Top module: `wcomb_top`

## Requirements
- R1: Writes with attribute bit 1 set, to the same 64-bit word and with equal attributes, leave as one beat; byte writes at offsets 0x0, 0x4 and 0x5 give a single beat with `w_strb` = 8'h31.
- R2: The strobe of every beat marks exactly the bytes written into it, and the data of those bytes is what was written; byte i of `w_data` is bits [8i+7:8i].
- R3: A write with attribute bit 1 clear leaves as its own beat, with its own strobe, data and attribute unchanged, and is never combined with any other write.
- R4: A modifiable write to a different word than the pending one makes the pending beat leave first; the new write then starts a new beat.
- R5: A device write arriving while a merged beat is pending leaves after that beat, so program order holds.
- R6: When a later merged write hits a byte that is already pending, the byte holds the later data.
- R7: A pending beat with no new write accepted leaves on its own: `aw_valid` rises on the 8th rising edge after the edge that accepted the last write, and not before.
- R8: Asserting `flush_in` makes the pending beat leave.
- R9: `aw_cache` equals the attribute of the writes in the beat. Writes with different attribute values are never merged. AW and W hold their values while they wait for ready.
- R10: After the B handshake of a beat, `done_pulse` is high for exactly as many cycles as the beat held original writes, with `done_resp` equal to the received `b_resp`; no pulse comes before that response.
- R11: `aw_addr` is always 64-bit aligned (bits [2:0] zero) and is the word address of the writes.
- R12: After reset, no AW, W or completion output is valid and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Write request valid |
| req_ready | output | 1 | Write request accepted this cycle |
| req_addr | input | 32 | Byte address of the write |
| req_data | input | 64 | Write data placed in its byte lanes |
| req_strb | input | 8 | Byte lanes written by the request |
| req_cache | input | 4 | Cache attribute; bit 1 is the modifiable flag |
| flush_in | input | 1 | Release the pending beat |
| aw_valid | output | 1 | Address valid |
| aw_ready | input | 1 | Address accepted |
| aw_addr | output | 32 | Word-aligned beat address |
| aw_cache | output | 4 | Attribute of the beat |
| w_valid | output | 1 | Data valid |
| w_ready | input | 1 | Data accepted |
| w_data | output | 64 | Beat data |
| w_strb | output | 8 | Beat byte strobe |
| b_valid | input | 1 | Write response valid |
| b_ready | output | 1 | Ready for write response |
| b_resp | input | 2 | Write response status |
| done_pulse | output | 1 | One cycle per completed original write |
| done_resp | output | 2 | Status for the current completion |

## Verification
The bench goes after several corner cases.
- Same-byte overwrite: a design that kept the first byte would send stale data.
- Same word, different attribute: a design that ignored the attribute would merge writes to two memory types into one beat.
- Device write behind a pending merged beat: a design that sent the device write straight out would reorder the writes.
- Idle timeout: it is timed to the exact edge, so an off-by-one counter is caught.
- Completion count: it is compared against the number of writes pushed, so a design that pulsed once per beat shows up at once.
- Error status: it is checked on the completions.

// File: rtl/wcomb_pkg.sv
package wcomb_pkg;

    localparam int ADDR_W  = 32;
    localparam int DATA_W  = 64;
    localparam int STRB_W  = DATA_W / 8;
    localparam int OFS_W   = $clog2(STRB_W);
    localparam int ATTR_W  = 4;
    localparam int MOD_BIT = 1;
    localparam int CNT_W   = 4;
    localparam int RESP_W  = 2;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] data_t;
    typedef logic [STRB_W-1:0] strb_t;
    typedef logic [ATTR_W-1:0] attr_t;
    typedef logic [CNT_W-1:0]  cnt_t;

    typedef struct packed {
        addr_t addr;
        data_t data;
        strb_t strb;
        attr_t attr;
        cnt_t  cnt;
    } beat_t;

    typedef enum logic [1:0] {
        ENG_IDLE,
        ENG_SEND,
        ENG_RESP,
        ENG_NOTE
    } eng_state_e;

    function automatic addr_t word_base(addr_t a);
        return {a[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};
    endfunction

    function automatic logic is_mod(attr_t a);
        return a[MOD_BIT];
    endfunction

    // Take the lanes selected by sel from nw, keep the rest from old.
    function automatic data_t lane_merge(data_t old, data_t nw, strb_t sel);
        data_t r;
        r = old;
        for (int i = 0; i < STRB_W; i++) begin
            if (sel[i]) r[8*i +: 8] = nw[8*i +: 8];
        end
        return r;
    endfunction

endpackage

// File: rtl/wcomb_gather.sv
module wcomb_gather
    import wcomb_pkg::*;
#(
    parameter int IDLE_CYCLES = 8
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  req_valid,
    output logic  req_ready,
    input  addr_t req_addr,
    input  data_t req_data,
    input  strb_t req_strb,
    input  attr_t req_attr,
    input  logic  flush_in,
    input  logic  eng_idle,
    output logic  launch,
    output beat_t beat
);

    localparam int IC_W = $clog2(IDLE_CYCLES + 1);
    localparam logic [IC_W-1:0] IDLE_LAST = IC_W'(IDLE_CYCLES - 1);

    beat_t           pend;
    logic            pend_v;
    logic            pend_dev;
    logic [IC_W-1:0] idle_cnt;

    logic same_word;
    logic can_merge;
    logic idle_hit;
    logic want_out;
    logic accept;

    always_comb begin
        same_word = (word_base(req_addr) == pend.addr);
        can_merge = pend_v && !pend_dev && is_mod(req_attr) && same_word
                    && (req_attr == pend.attr) && (pend.cnt != '1);
        idle_hit  = (idle_cnt == IDLE_LAST);
        want_out  = pend_v && (pend_dev || flush_in || idle_hit
                               || (req_valid && !can_merge));
        launch    = want_out && eng_idle;
        req_ready = !launch && (!pend_v || can_merge);
        accept    = req_valid && req_ready;
        beat      = pend;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend     <= '0;
            pend_v   <= 1'b0;
            pend_dev <= 1'b0;
            idle_cnt <= '0;
        end else if (launch) begin
            pend_v   <= 1'b0;
            pend_dev <= 1'b0;
            idle_cnt <= '0;
        end else if (accept) begin
            idle_cnt <= '0;
            if (!pend_v) begin
                pend.addr <= word_base(req_addr);
                pend.data <= lane_merge('0, req_data, req_strb);
                pend.strb <= req_strb;
                pend.attr <= req_attr;
                pend.cnt  <= cnt_t'(1);
                pend_v    <= 1'b1;
                pend_dev  <= !is_mod(req_attr);
            end else begin
                pend.data <= lane_merge(pend.data, req_data, req_strb);
                pend.strb <= pend.strb | req_strb;
                pend.cnt  <= pend.cnt + cnt_t'(1);
            end
        end else if (pend_v && !idle_hit) begin
            idle_cnt <= idle_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/wcomb_engine.sv
module wcomb_engine
    import wcomb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              launch,
    input  beat_t             beat_in,
    output logic              idle,
    output logic              aw_valid,
    input  logic              aw_ready,
    output addr_t             aw_addr,
    output attr_t             aw_cache,
    output logic              w_valid,
    input  logic              w_ready,
    output data_t             w_data,
    output strb_t             w_strb,
    input  logic              b_valid,
    output logic              b_ready,
    input  logic [RESP_W-1:0] b_resp,
    output logic              done_pulse,
    output logic [RESP_W-1:0] done_resp
);

    eng_state_e        state;
    beat_t             cur;
    logic              aw_sent;
    logic              w_sent;
    cnt_t              remain;
    logic [RESP_W-1:0] resp_q;

    logic aw_hs;
    logic w_hs;

    always_comb begin
        idle       = (state == ENG_IDLE);
        aw_valid   = (state == ENG_SEND) && !aw_sent;
        w_valid    = (state == ENG_SEND) && !w_sent;
        aw_addr    = cur.addr;
        aw_cache   = cur.attr;
        w_data     = cur.data;
        w_strb     = cur.strb;
        b_ready    = (state == ENG_RESP);
        done_pulse = (state == ENG_NOTE);
        done_resp  = resp_q;
        aw_hs      = aw_valid && aw_ready;
        w_hs       = w_valid && w_ready;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ENG_IDLE;
            cur     <= '0;
            aw_sent <= 1'b0;
            w_sent  <= 1'b0;
            remain  <= '0;
            resp_q  <= '0;
        end else begin
            case (state)
                ENG_IDLE: begin
                    if (launch) begin
                        cur     <= beat_in;
                        remain  <= beat_in.cnt;
                        aw_sent <= 1'b0;
                        w_sent  <= 1'b0;
                        state   <= ENG_SEND;
                    end
                end
                ENG_SEND: begin
                    if (aw_hs) aw_sent <= 1'b1;
                    if (w_hs)  w_sent  <= 1'b1;
                    if ((aw_sent || aw_hs) && (w_sent || w_hs)) state <= ENG_RESP;
                end
                ENG_RESP: begin
                    if (b_valid) begin
                        resp_q <= b_resp;
                        state  <= ENG_NOTE;
                    end
                end
                ENG_NOTE: begin
                    remain <= remain - cnt_t'(1);
                    if (remain == cnt_t'(1)) state <= ENG_IDLE;
                end
                default: state <= ENG_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/wcomb_top.sv
module wcomb_top
    import wcomb_pkg::*;
#(
    parameter int IDLE_CYCLES = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [31:0] req_addr,
    input  logic [63:0] req_data,
    input  logic [7:0]  req_strb,
    input  logic [3:0]  req_cache,
    input  logic        flush_in,
    output logic        aw_valid,
    input  logic        aw_ready,
    output logic [31:0] aw_addr,
    output logic [3:0]  aw_cache,
    output logic        w_valid,
    input  logic        w_ready,
    output logic [63:0] w_data,
    output logic [7:0]  w_strb,
    input  logic        b_valid,
    output logic        b_ready,
    input  logic [1:0]  b_resp,
    output logic        done_pulse,
    output logic [1:0]  done_resp
);

    logic  eng_idle;
    logic  launch;
    beat_t beat;

    wcomb_gather #(
        .IDLE_CYCLES(IDLE_CYCLES)
    ) u_gather (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_addr  (req_addr),
        .req_data  (req_data),
        .req_strb  (req_strb),
        .req_attr  (req_cache),
        .flush_in  (flush_in),
        .eng_idle  (eng_idle),
        .launch    (launch),
        .beat      (beat)
    );

    wcomb_engine u_engine (
        .clk        (clk),
        .rst        (rst),
        .launch     (launch),
        .beat_in    (beat),
        .idle       (eng_idle),
        .aw_valid   (aw_valid),
        .aw_ready   (aw_ready),
        .aw_addr    (aw_addr),
        .aw_cache   (aw_cache),
        .w_valid    (w_valid),
        .w_ready    (w_ready),
        .w_data     (w_data),
        .w_strb     (w_strb),
        .b_valid    (b_valid),
        .b_ready    (b_ready),
        .b_resp     (b_resp),
        .done_pulse (done_pulse),
        .done_resp  (done_resp)
    );

endmodule

// File: rtl/wcomb_checker.sv
module wcomb_checker (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic        req_ready,
    input logic [3:0]  req_cache,
    input logic        aw_valid,
    input logic        aw_ready,
    input logic [31:0] aw_addr,
    input logic [3:0]  aw_cache,
    input logic        w_valid,
    input logic        w_ready,
    input logic [63:0] w_data,
    input logic [7:0]  w_strb,
    input logic        b_ready,
    input logic        done_pulse
);

    a_r11_aw_aligned: assert property (@(posedge clk) disable iff (rst)
        aw_valid |-> (aw_addr[2:0] == 3'b000));

    a_r2_strb_nonzero: assert property (@(posedge clk) disable iff (rst)
        w_valid |-> (w_strb != 8'h00));

    a_r9_aw_hold: assert property (@(posedge clk) disable iff (rst)
        aw_valid && !aw_ready |=> aw_valid && $stable(aw_addr) && $stable(aw_cache));

    a_r2_w_hold: assert property (@(posedge clk) disable iff (rst)
        w_valid && !w_ready |=> w_valid && $stable(w_strb) && $stable(w_data));

    a_r10_done_quiet: assert property (@(posedge clk) disable iff (rst)
        done_pulse |-> !aw_valid && !w_valid && !b_ready);

    a_r3_device_alone: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready && !req_cache[1] |=> !req_ready);

endmodule

bind wcomb_top wcomb_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_cache  (req_cache),
    .aw_valid   (aw_valid),
    .aw_ready   (aw_ready),
    .aw_addr    (aw_addr),
    .aw_cache   (aw_cache),
    .w_valid    (w_valid),
    .w_ready    (w_ready),
    .w_data     (w_data),
    .w_strb     (w_strb),
    .b_ready    (b_ready),
    .done_pulse (done_pulse)
);

// File: tb/sim_wcomb_top.sv
`timescale 1ns/1ps
module sim_wcomb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic [63:0] req_data = '0;
    logic [7:0]  req_strb = '0;
    logic [3:0]  req_cache = '0;
    logic        flush_in = 1'b0;
    logic        aw_valid;
    logic        aw_ready = 1'b1;
    logic [31:0] aw_addr;
    logic [3:0]  aw_cache;
    logic        w_valid;
    logic        w_ready = 1'b1;
    logic [63:0] w_data;
    logic [7:0]  w_strb;
    logic        b_valid = 1'b0;
    logic        b_ready;
    logic [1:0]  b_resp = 2'b00;
    logic        done_pulse;
    logic [1:0]  done_resp;

    always #10 clk = ~clk;

    wcomb_top u0 (.*);

    int n_tests = 0;
    int n_fail  = 0;
    bit ended   = 0;

    logic [31:0] log_addr  [64];
    logic [3:0]  log_cache [64];
    logic [63:0] log_data  [64];
    logic [7:0]  log_strb  [64];
    int n_aw = 0;
    int n_w = 0;
    int n_done = 0;
    int owed = 0;
    logic [1:0] resp_to_send = 2'b00;
    logic [1:0] last_done_resp = 2'b00;
    bit b_taken = 0;

    // Slave model: samples between edges, so what it sees is what the next edge takes.
    initial begin
        forever begin
            @(negedge clk);
            if (aw_valid && aw_ready) begin
                log_addr[n_aw % 64]  = aw_addr;
                log_cache[n_aw % 64] = aw_cache;
                n_aw++;
            end
            if (w_valid && w_ready) begin
                log_data[n_w % 64] = w_data;
                log_strb[n_w % 64] = w_strb;
                n_w++;
                owed++;
            end
            if (done_pulse) begin
                n_done++;
                last_done_resp = done_resp;
            end
            if (b_valid && b_ready) begin
                b_taken = 1;
            end else if (b_taken) begin
                b_valid = 1'b0;
                b_taken = 0;
                owed--;
            end else if (!b_valid && owed > 0) begin
                b_valid = 1'b1;
                b_resp  = resp_to_send;
            end
        end
    end

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic push(input logic [31:0] a, input logic [7:0] b, input logic [3:0] attr);
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        req_strb  = 8'h01 << a[2:0];
        req_data  = 64'(b) << (8 * a[2:0]);
        req_cache = attr;
        #1;
        while (!req_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        #1;
        req_valid = 1'b0;
    endtask

    task automatic drain(input int aw_target, input int done_target);
        int guard;
        guard = 0;
        @(negedge clk);
        flush_in = 1'b1;
        while (n_aw < aw_target && guard < 200) begin
            @(negedge clk);
            guard++;
        end
        flush_in = 1'b0;
        while (n_done < done_target && guard < 400) begin
            @(negedge clk);
            guard++;
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic check_beat(input int idx, input string tag, input logic [31:0] a,
                              input logic [7:0] s, input logic [63:0] d, input logic [3:0] c);
        check(log_addr[idx] == a, {tag, " addr"}, 64'(log_addr[idx]), 64'(a));
        check(log_strb[idx] == s, {tag, " strb"}, 64'(log_strb[idx]), 64'(s));
        check(log_data[idx] == d, {tag, " data"}, log_data[idx], d);
        check(log_cache[idx] == c, {tag, " cache"}, 64'(log_cache[idx]), 64'(c));
    endtask

    task automatic t_reset();
        check(!aw_valid && !w_valid, "R12 aw/w idle", 64'({aw_valid, w_valid}), 64'd0);
        check(!done_pulse, "R12 done idle", 64'(done_pulse), 64'd0);
        check(req_ready, "R12 ready", 64'(req_ready), 64'd1);
    endtask

    task automatic t_merge();
        int b0, d0;
        b0 = n_aw; d0 = n_done;
        push(32'h0000_0000, 8'h11, 4'h3);
        push(32'h0000_0004, 8'h44, 4'h3);
        push(32'h0000_0005, 8'h55, 4'h3);
        drain(b0 + 1, d0 + 3);
        check(n_aw == b0 + 1, "R1 one beat", 64'(n_aw - b0), 64'd1);
        check_beat(b0, "R1 R2 R11 merged", 32'h0, 8'h31, 64'h0000_5544_0000_0011, 4'h3);
        check(n_done == d0 + 3, "R10 pulses", 64'(n_done - d0), 64'd3);
    endtask

    task automatic t_device();
        int b0, d0;
        b0 = n_aw; d0 = n_done;
        push(32'h1000_0000, 8'hA1, 4'h0);
        push(32'h1000_0001, 8'hB2, 4'h0);
        drain(b0 + 2, d0 + 2);
        check(n_aw == b0 + 2, "R3 two beats", 64'(n_aw - b0), 64'd2);
        check_beat(b0,     "R3 dev0", 32'h1000_0000, 8'h01, 64'h0000_0000_0000_00A1, 4'h0);
        check_beat(b0 + 1, "R3 dev1", 32'h1000_0000, 8'h02, 64'h0000_0000_0000_B200, 4'h0);
    endtask

    task automatic t_new_word();
        int b0, d0;
        b0 = n_aw; d0 = n_done;
        push(32'h0000_0040, 8'h01, 4'h3);
        push(32'h0000_004B, 8'h02, 4'h3);
        drain(b0 + 2, d0 + 2);
        check(n_aw == b0 + 2, "R4 two beats", 64'(n_aw - b0), 64'd2);
        check_beat(b0,     "R4 first", 32'h40, 8'h01, 64'h01, 4'h3);
        check_beat(b0 + 1, "R4 second", 32'h48, 8'h08, 64'h0200_0000, 4'h3);
    endtask

    task automatic t_dev_after_merge();
        int b0, d0;
        b0 = n_aw; d0 = n_done;
        push(32'h0000_0080, 8'h5A, 4'h3);
        push(32'h0000_0084, 8'hC3, 4'h1);
        drain(b0 + 2, d0 + 2);
        check_beat(b0,     "R5 merged first", 32'h80, 8'h01, 64'h5A, 4'h3);
        check_beat(b0 + 1, "R5 device second", 32'h80, 8'h10, 64'h0000_00C3_0000_0000, 4'h1);
    endtask

    task automatic t_overwrite();
        int b0, d0;
        b0 = n_aw; d0 = n_done;
        push(32'h0000_00C0, 8'hAA, 4'hF);
        push(32'h0000_00C0, 8'h55, 4'hF);
        push(32'h0000_00C1, 8'h66, 4'hF);
        drain(b0 + 1, d0 + 3);
        check(n_aw == b0 + 1, "R6 one beat", 64'(n_aw - b0), 64'd1);
        check_beat(b0, "R6 last wins", 32'hC0, 8'h03, 64'h6655, 4'hF);
        check(n_done == d0 + 3, "R10 overwrite pulses", 64'(n_done - d0), 64'd3);
    endtask

    task automatic t_timeout();
        int d0;
        d0 = n_done;
        push(32'h0000_0200, 8'h77, 4'h3);
        repeat (7) @(posedge clk);
        #2;
        check(!aw_valid, "R7 not before 8", 64'(aw_valid), 64'd0);
        @(posedge clk);
        #2;
        check(aw_valid, "R7 at 8", 64'(aw_valid), 64'd1);
        check(aw_addr == 32'h200, "R7 addr", 64'(aw_addr), 64'h200);
        repeat (10) @(negedge clk);
        check(n_done == d0 + 1, "R10 timeout pulse", 64'(n_done - d0), 64'd1);
    endtask

    task automatic t_flush();
        int b0;
        b0 = n_aw;
        push(32'h0000_0300, 8'h12, 4'h2);
        @(negedge clk);
        flush_in = 1'b1;
        @(negedge clk);
        flush_in = 1'b0;
        repeat (2) @(negedge clk);
        check(n_aw == b0 + 1, "R8 flush beat", 64'(n_aw - b0), 64'd1);
        repeat (8) @(negedge clk);
    endtask

    task automatic t_attr_split();
        int b0, d0;
        b0 = n_aw; d0 = n_done;
        push(32'h0000_0100, 8'h10, 4'h3);
        push(32'h0000_0101, 8'h20, 4'hF);
        drain(b0 + 2, d0 + 2);
        check(n_aw == b0 + 2, "R9 not merged", 64'(n_aw - b0), 64'd2);
        check_beat(b0,     "R9 first", 32'h100, 8'h01, 64'h10, 4'h3);
        check_beat(b0 + 1, "R9 second", 32'h100, 8'h02, 64'h2000, 4'hF);
    endtask

    task automatic t_resp();
        int d0;
        d0 = n_done;
        resp_to_send = 2'b10;
        push(32'h1000_0010, 8'h99, 4'h0);
        drain(n_aw + 1, d0 + 1);
        check(last_done_resp == 2'b10, "R10 resp", 64'(last_done_resp), 64'd2);
        resp_to_send = 2'b00;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!ended) begin
            ended = 1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_merge();
        t_device();
        t_new_word();
        t_dev_after_merge();
        t_overwrite();
        t_timeout();
        t_flush();
        t_attr_split();
        t_resp();
        if (!ended) begin
            ended = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule